// File: doc/BRIEF.md
# Cascaded Minimal-Polynomial Remainder Divider

This block is the front half of a binary BCH encoder whose correction strength can change from one packet to the next. It never builds the long generator polynomial. Instead it runs a chain of short degree-M LFSR dividers, one for each odd minimal polynomial. The first divider takes the message bits. Every later divider takes the quotient bits that the divider ahead of it produces in the same cycle. Each divider does one step per clock. The feedback of any one divider therefore drives no more XORs than the weight of its own polynomial, at most M.

Message bits arrive one per cycle through a valid/ready input, most significant coefficient first. Each accepted bit is also sent out unchanged, one cycle later, as a systematic information bit. A strength input sets how many dividers take part in the packet. Raising the strength by one adds one divider to the chain, and no stored polynomial has to be swapped. When the last bit has been absorbed, the block pulses a done strobe. At that point every divider's remainder is on a parallel port, ready for the downstream weighting and combining network.

Top module: `cbd_cascade_divider`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `infoValid` are 0, `remOut` is all zeros and `inReady` is 1.
- R2: A bit accepted at a clock edge (`inValid` and `inReady` both 1) appears on `infoData`, with `infoValid` at 1, in the cycle that follows that edge. Bits keep their order. In a cycle where no bit was accepted at the edge before it, `infoValid` is 0.
- R3: Stage 0 holds the remainder of s·x^M divided by POLYS[0], where s is the packet's message taken with the first bit as the highest coefficient. A polynomial entry has bit j equal to the coefficient of x^j, with bits M and 0 set. Stage i appears on `remOut[i*M +: M]`, and its bit M-1 is the coefficient of x^(M-1).
- R4: Stage i (i ≥ 1) is fed the quotient bit stream of stage i-1, highest coefficient first. Its remainder is that of q·x^M divided by POLYS[i], where q is the quotient of the stage ahead of it.
- R5: The active stage count is taken from `strength` on the first accepted bit of a packet and is held to at most T_MAX. Values above T_MAX behave as T_MAX. Stages at index count or higher read zero for the whole packet. Changes on `strength` after the first bit have no effect.
- R6: `done` is 1 for exactly one cycle, in the cycle after the packet's last bit (the one with `inLast` at 1) is accepted. In that cycle `remOut` is final and `inReady` is 0.
- R7: Between packets, and in gap cycles inside a packet where `inValid` is 0, `remOut` does not change. The first accepted bit of the next packet restarts all stages from zero, even when it is offered back to back right after `done`.
- R8: A packet of a single bit, with `inLast` set on its first accepted bit, starts, divides and finishes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| strength | input | $clog2(T_MAX+1) | Requested number of active divider stages |
| inValid | input | 1 | Message bit offered |
| inData | input | 1 | Message bit |
| inLast | input | 1 | Offered bit is the last of its packet |
| inReady | output | 1 | Block can accept a bit at the next edge |
| infoValid | output | 1 | Systematic information bit valid |
| infoData | output | 1 | Systematic information bit |
| done | output | 1 | One-cycle strobe: remainders are final |
| remOut | output | T_MAX*M | Stage remainders, stage i at bits [i*M +: M] |

## Verification
Two things coincide on the first accepted bit of a packet: the stages are cleared and the first division step is taken. Both happen on one edge, so a stale remainder or a stale stage count would mix into the new result. The bench provokes this in two ways. It sends packets back to back, holding `inValid` high through the `done` cycle. It also sends single-bit packets, where the start and the end of the packet fall on the same bit. Each case is judged by comparing `remOut` with a long-division model that starts from zero.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  // Strobes from the control to the divider datapath.
  typedef struct packed {
    logic clear;  // first beat of a packet: restart every stage from zero
    logic step;   // a bit is accepted this cycle
  } cbdStrobe_t;

endpackage

// File: rtl/cbd_ctrl.sv
module cbd_ctrl
  import cbd_pkg::*;
#(
  parameter int T_MAX = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       inLast,
  input  logic [$clog2(T_MAX+1)-1:0] strength,
  output logic                       inReady,
  output logic                       done,
  output cbdStrobe_t                 strb,
  output logic [T_MAX-1:0]           actMask
);

  localparam int CW = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] CAP = CW'(T_MAX);

  logic          inPkt;
  logic          doneQ;
  logic [CW-1:0] cntQ;
  logic [CW-1:0] reqCnt;
  logic [CW-1:0] useCnt;
  logic          beat;
  logic          start;

  assign inReady = ~doneQ;
  assign done    = doneQ;
  assign beat    = inValid & ~doneQ;
  assign start   = beat & ~inPkt;
  assign reqCnt  = (strength > CAP) ? CAP : strength;
  assign useCnt  = start ? reqCnt : cntQ;

  assign strb.clear = start;
  assign strb.step  = beat;

  for (genvar i = 0; i < T_MAX; i++) begin : g_mask
    assign actMask[i] = (useCnt > CW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= beat & inLast;
      if (beat) inPkt <= ~inLast;
      if (start) cntQ <= reqCnt;
    end
  end

  // R5: the latched count never exceeds the stage count
  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CAP);

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R6: a finished packet leaves the control idle
  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !inPkt);

endmodule

// File: rtl/cbd_stage.sv
module cbd_stage #(
  parameter int         M    = 5,
  parameter logic [M:0] POLY = 6'b100101
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         en,
  input  logic         inBit,
  output logic         quotBit,
  output logic [M-1:0] rem
);

  logic [M-1:0] remQ;
  logic [M-1:0] base;
  logic [M-1:0] nxt;
  logic         fb;

  // The incoming bit joins the feedback after the top delay element.
  assign base    = clear ? '0 : remQ;
  assign fb      = inBit ^ base[M-1];
  assign nxt     = {base[M-2:0], 1'b0} ^ ({M{fb}} & POLY[M-1:0]);
  assign quotBit = en & fb;
  assign rem     = remQ;

  always_ff @(posedge clk) begin
    if (!rstN)      remQ <= '0;
    else if (en)    remQ <= nxt;
    else if (clear) remQ <= '0;
  end

  // R7: an idle stage keeps its remainder
  p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !clear) |=> $stable(remQ));

endmodule

// File: rtl/cbd_datapath.sv
module cbd_datapath
  import cbd_pkg::*;
#(
  parameter int                     M     = 5,
  parameter int                     T_MAX = 4,
  parameter logic [T_MAX-1:0][M:0]  POLYS = {6'b101111, 6'b110111, 6'b111101, 6'b100101}
) (
  input  logic               clk,
  input  logic               rstN,
  input  cbdStrobe_t         strb,
  input  logic [T_MAX-1:0]   actMask,
  input  logic               inBit,
  output logic [T_MAX*M-1:0] remOut
);

  logic [T_MAX:0] chain;

  assign chain[0] = inBit;

  for (genvar i = 0; i < T_MAX; i++) begin : g_stage
    logic [M-1:0] rem;

    cbd_stage #(.M(M), .POLY(POLYS[i])) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strb.clear),
      .en     (strb.step & actMask[i]),
      .inBit  (chain[i]),
      .quotBit(chain[i+1]),
      .rem    (rem)
    );

    assign remOut[i*M +: M] = rem;

    // R5: a stage left out of the packet reads zero
    p_inactive_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.step && !actMask[i]) |=> (remOut[i*M +: M] == '0));
  end

  // R4: the quotient leaving the chain is quiet when nothing is accepted
  p_chain_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |-> (chain[T_MAX] == 1'b0));

endmodule

// File: rtl/cbd_cascade_divider.sv
module cbd_cascade_divider
  import cbd_pkg::*;
#(
  parameter int                     M     = 5,
  parameter int                     T_MAX = 4,
  parameter logic [T_MAX-1:0][M:0]  POLYS = {6'b101111, 6'b110111, 6'b111101, 6'b100101}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(T_MAX+1)-1:0] strength,
  input  logic                       inValid,
  input  logic                       inData,
  input  logic                       inLast,
  output logic                       inReady,
  output logic                       infoValid,
  output logic                       infoData,
  output logic                       done,
  output logic [T_MAX*M-1:0]         remOut
);

  cbdStrobe_t       strb;
  logic [T_MAX-1:0] actMask;

  cbd_ctrl #(.T_MAX(T_MAX)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .strength(strength),
    .inReady (inReady),
    .done    (done),
    .strb    (strb),
    .actMask (actMask)
  );

  cbd_datapath #(.M(M), .T_MAX(T_MAX), .POLYS(POLYS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .actMask(actMask),
    .inBit  (inData),
    .remOut (remOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      infoValid <= 1'b0;
      infoData  <= 1'b0;
    end else begin
      infoValid <= strb.step;
      infoData  <= inData;
    end
  end

  // R2: accepted bit comes out on the next cycle
  p_info_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (infoValid && infoData == $past(inData)));

  // R7: no accepted bit, no change of remainders
  p_rem_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> $stable(remOut));

endmodule

// File: tb/sim_cbd_cascade_divider.sv
`timescale 1ns/1ps
module sim_cbd_cascade_divider;

  localparam int M    = 5;
  localparam int TM   = 4;
  localparam int CW   = $clog2(TM + 1);
  localparam int MAXL = 48;
  localparam logic [TM-1:0][M:0] BP = {6'b101111, 6'b110111, 6'b111101, 6'b100101};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [CW-1:0]   strength = '0;
  logic            inValid = 1'b0;
  logic            inData = 1'b0;
  logic            inLast = 1'b0;
  logic            inReady, infoValid, infoData, done;
  logic [TM*M-1:0] remOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  cbd_cascade_divider #(.M(M), .T_MAX(TM), .POLYS(BP)) u0 (
    .clk(clk), .rstN(rstN), .strength(strength), .inValid(inValid),
    .inData(inData), .inLast(inLast), .inReady(inReady),
    .infoValid(infoValid), .infoData(infoData), .done(done), .remOut(remOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Long division by each active polynomial in turn, working on bit lists.
  function automatic logic [TM*M-1:0] model(input logic [MAXL-1:0] msg,
                                            input int len, input int str);
    logic [TM*M-1:0] res = '0;
    logic [MAXL-1:0] cur = msg;
    logic [MAXL-1:0] quo;
    logic            work [0:MAXL+M-1];
    int cnt = (str > TM) ? TM : str;
    for (int st = 0; st < cnt; st++) begin
      quo = '0;
      for (int j = 0; j < MAXL + M; j++) work[j] = (j < len) ? cur[j] : 1'b0;
      for (int j = 0; j < len; j++) begin
        quo[j] = work[j];
        if (work[j])
          for (int b = 0; b <= M; b++) work[j+b] = work[j+b] ^ BP[st][M-b];
      end
      for (int b = 0; b < M; b++) res[st*M + (M-1-b)] = work[len+b];
      cur = quo;
    end
    return res;
  endfunction

  // msg[0] is the first bit sent (highest coefficient).
  task automatic sendPacket(input logic [MAXL-1:0] msg, input int len,
                            input int str, input bit b2b, input string tag);
    logic [TM*M-1:0] expRem = model(msg, len, str);
    logic [TM*M-1:0] held;
    int infoBad = 0;
    bit acc;
    for (int j = 0; j < len; j++) begin
      if (j > 0 && ($urandom % 4) == 0) begin
        inValid = 1'b0;
        inData  = 1'($urandom);
        @(negedge clk);
        if (infoValid) infoBad++;
      end
      inValid  = 1'b1;
      inData   = msg[j];
      inLast   = (j == len - 1);
      strength = (j == 0) ? CW'(str) : CW'($urandom);
      do begin
        acc = inReady;
        @(negedge clk);
      end while (!acc);
      if (!(infoValid && infoData == msg[j])) infoBad++;
    end
    chk(infoBad == 0, "R2", "info bits echoed", 64'(infoBad), 64'd0);
    chk(done == 1'b1, "R6", "done after last bit", 64'(done), 64'd1);
    chk(inReady == 1'b0, "R6", "ready low during done", 64'(inReady), 64'd0);
    chk(remOut == expRem, tag, "stage remainders", 64'(remOut), 64'(expRem));
    inLast = 1'b0;
    if (!b2b) begin
      inValid = 1'b0;
      held = remOut;
      @(negedge clk);
      chk(done == 1'b0, "R6", "done one cycle", 64'(done), 64'd0);
      repeat (1 + $urandom % 3) begin
        inData   = 1'($urandom);
        strength = CW'($urandom);
        @(negedge clk);
      end
      chk(remOut == held, "R7", "remainders held when idle", 64'(remOut), 64'(held));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [MAXL-1:0] m;
    int len;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && infoValid == 1'b0, "R1", "flags in reset", {62'd0, done, infoValid}, 64'd0);
    chk(remOut == '0, "R1", "remainders in reset", 64'(remOut), 64'd0);
    chk(inReady == 1'b1, "R1", "ready in reset", 64'(inReady), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(remOut == '0 && done == 1'b0, "R1", "state after reset", 64'(remOut), 64'd0);

    // Directed corner cases
    sendPacket(48'h1, 1, 4, 1'b0, "R8");
    sendPacket(48'h0, 10, 4, 1'b0, "R3");
    sendPacket(48'h1, 1, 1, 1'b0, "R3");
    sendPacket(48'hA5_3C_0F_96_71, 40, 1, 1'b0, "R3");
    sendPacket(48'h9F_0E_C3_21, 32, 2, 1'b0, "R4");
    sendPacket(48'h3_7B_DE_55, 27, 7, 1'b0, "R5");
    sendPacket(48'hFF_FF_FF, 24, 0, 1'b0, "R5");
    sendPacket(48'h12_34_56, 22, 3, 1'b0, "R5");
    // Back to back: start clear meets first step after done
    sendPacket(48'hFFFF_FFFF, 30, 4, 1'b1, "R4");
    sendPacket(48'h1, 1, 4, 1'b1, "R7");
    sendPacket(48'h6D_A2_19, 21, 2, 1'b0, "R7");

    // Random packets
    for (int p = 0; p < 40; p++) begin
      m   = MAXL'({$urandom, $urandom});
      len = 1 + ($urandom % MAXL);
      sendPacket(m, len, $urandom % 8, ($urandom % 3) == 0, (len == 1) ? "R8" : "R4");
    end
    inValid = 1'b0;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule